// File: doc/BRIEF.md
# Manchester II Frame Encoder

This block turns a bit stream supplied one bit at a time on a serial input into Manchester II frames of the kind used on command/response avionics buses. A one-cycle send request, made while the block is idle, starts a frame. The frame has three parts, in order:

- a sync pattern three bit periods long;
- between 2 and 28 data bits;
- one parity bit.

The block drives two line outputs, one for each polarity of the line. Both outputs are low whenever no frame is on the line. The block runs on a clock at twice the bit rate, so each bit period is two clock cycles (half-cells).

The host reads the data from the block's shift strobe. One bit period before each data bit goes on the line, the strobe pulses for one cycle. The host then presents that bit on the serial input. The settings for a frame are taken at the moment the send request is accepted and are held until the frame ends:

- the word length;
- the sync type, command or data;
- the parity sense, odd or even.

An inhibit input silences the line without stopping the frame sequencing. A synchronous master reset returns the block to idle.

Top module: `manch_frame_enc`

## Requirements
- R1: While rst is high at a clock edge, and in the cycle after it, busy, line_pos, line_neg and shift_stb are all 0. A reset in the middle of a frame abandons that frame.
- R2: A send pulse sampled high while busy is 0 makes busy rise after that same edge. The frame occupies half-cells h = 0 to 2(N+4)-1, one per cycle. After the last half-cell busy returns to 0.
- R3: Sync occupies h = 0 to 5. With cmd_sync = 1, line_pos is high for h 0..2 and line_neg is high for h 3..5. With cmd_sync = 0, the pattern is inverted.
- R4: Data bit k (k = 0..N-1, in the order the host presents them) occupies h = 6+2k and 7+2k. A 1 is sent as line_pos then line_neg. A 0 is sent as line_neg then line_pos.
- R5: shift_stb is high for exactly one cycle at each h = 4+2k, for k = 0..N-1, giving N pulses per frame. Data bit k is the value of ser_in at the clock edge that ends half-cell 5+2k.
- R6: The parity bit occupies the last two half-cells and uses the same Manchester coding as data. With odd_par = 1, the number of ones across the data and the parity bit is odd. With odd_par = 0, that number is even.
- R7: N equals word_len, limited to the range 2..28: a value of 0 or 1 gives 2, and a value of 29 to 31 gives 28.
- R8: While inhibit is high, line_pos and line_neg are 0. busy and shift_stb follow their normal timing regardless of inhibit.
- R9: line_pos and line_neg are never both high. While busy is high and inhibit is low, exactly one of them is high.
- R10: A send pulse while busy is high is ignored. Changes to word_len, cmd_sync and odd_par during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high master reset |
| send | input | 1 | Frame start request, accepted only when idle |
| word_len | input | 5 | Number of data bits, limited to 2..28 |
| cmd_sync | input | 1 | 1 selects command sync, 0 selects data sync |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| ser_in | input | 1 | Serial data bit from the host |
| inhibit | input | 1 | Forces both line outputs low |
| line_pos | output | 1 | Line driven to the positive state |
| line_neg | output | 1 | Line driven to the negative state |
| shift_stb | output | 1 | One-cycle request for the next data bit |
| busy | output | 1 | A frame is in progress |

## Verification
All frame outputs depend only on registered state, so half-cell h of a frame is visible in the (h+1)th cycle after the edge that accepted send. The bench counts cycles from that edge and compares each output at the falling edge of every cycle. The bench answers each shift_stb pulse by changing ser_in at the falling edge where it sees the pulse. That bit is captured two rising edges later, and it goes on the line in the cycle after the capture. Each frame also checks the following:

- busy is high for exactly 2(N+4) sampled cycles, then low;
- a reset asserted in the middle of a frame clears every output in the cycle that follows.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

    localparam int LEN_W      = 5;
    localparam int HALF_W     = 6;
    localparam int MIN_BITS   = 2;
    localparam int MAX_BITS   = 28;
    localparam int SYNC_HALFS = 6;

    typedef enum logic [1:0] {
        SEG_IDLE,
        SEG_SYNC,
        SEG_DATA,
        SEG_PAR
    } seg_e;

    typedef struct packed {
        logic [LEN_W-1:0] nbits;
        logic             cmd;
        logic             odd;
    } cfg_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        if (raw < LEN_W'(MIN_BITS))
            return LEN_W'(MIN_BITS);
        else if (raw > LEN_W'(MAX_BITS))
            return LEN_W'(MAX_BITS);
        else
            return raw;
    endfunction

    // half-cell index of the final parity half: 2N + 7
    function automatic logic [HALF_W-1:0] last_half(input logic [LEN_W-1:0] n);
        return {n, 1'b0} + HALF_W'(SYNC_HALFS + 1);
    endfunction

endpackage

// File: rtl/mfe_seq.sv
module mfe_seq
    import mfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              send,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              sync_in,
    input  logic              odd_in,
    output logic              active,
    output logic [HALF_W-1:0] hc,
    output cfg_t              cfg,
    output seg_e              seg,
    output logic              strobe,
    output logic              load_bit
);

    logic [HALF_W-1:0] twice_n;
    logic              at_end;

    assign twice_n = {cfg.nbits, 1'b0};
    assign at_end  = (hc == last_half(cfg.nbits));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            hc     <= '0;
            cfg    <= '0;
        end else if (!active) begin
            if (send) begin
                active <= 1'b1;
                hc     <= '0;
                cfg    <= '{nbits: clamp_len(len_in), cmd: sync_in, odd: odd_in};
            end
        end else if (at_end) begin
            active <= 1'b0;
            hc     <= '0;
        end else begin
            hc <= hc + 1'b1;
        end
    end

    always_comb begin
        if (!active)
            seg = SEG_IDLE;
        else if (hc < HALF_W'(SYNC_HALFS))
            seg = SEG_SYNC;
        else if (hc < twice_n + HALF_W'(SYNC_HALFS))
            seg = SEG_DATA;
        else
            seg = SEG_PAR;
    end

    // strobe one bit period ahead of data bit k: h = 4 + 2k
    assign strobe   = active && !hc[0] && (hc >= HALF_W'(SYNC_HALFS - 2))
                      && (hc <= twice_n + HALF_W'(SYNC_HALFS - 4));
    // capture at the edge ending h = 5 + 2k
    assign load_bit = active && hc[0] && (hc >= HALF_W'(SYNC_HALFS - 1))
                      && (hc <= twice_n + HALF_W'(SYNC_HALFS - 3));

    a_r2_hc_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> hc <= last_half(cfg.nbits));

    a_r7_len_range: assert property (@(posedge clk) disable iff (rst)
        active |-> (cfg.nbits >= LEN_W'(MIN_BITS) && cfg.nbits <= LEN_W'(MAX_BITS)));

    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (active && !at_end) |=> $stable(cfg));

    a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    a_r5_load_after_strobe: assert property (@(posedge clk) disable iff (rst)
        load_bit |-> $past(strobe));

endmodule

// File: rtl/mfe_shift.sv
module mfe_shift (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic load_bit,
    input  logic ser_in,
    output logic cur_bit,
    output logic par_acc
);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cur_bit <= 1'b0;
            par_acc <= 1'b0;
        end else if (load_bit) begin
            cur_bit <= ser_in;
            par_acc <= par_acc ^ ser_in;
        end
    end

endmodule

// File: rtl/mfe_line.sv
module mfe_line
    import mfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seg_e              seg,
    input  logic [HALF_W-1:0] hc,
    input  logic              cmd,
    input  logic              odd,
    input  logic              cur_bit,
    input  logic              par_acc,
    input  logic              inhibit,
    output logic              pos,
    output logic              neg
);

    logic level;
    logic drive;

    always_comb begin
        unique case (seg)
            SEG_SYNC: level = (hc < HALF_W'(SYNC_HALFS / 2)) ? cmd : !cmd;
            SEG_DATA: level = cur_bit ^ hc[0];
            SEG_PAR:  level = (par_acc ^ odd) ^ hc[0];
            default:  level = 1'b0;
        endcase
    end

    assign drive = (seg != SEG_IDLE) && !inhibit;
    assign pos   = drive && level;
    assign neg   = drive && !level;

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pos && neg));

    a_r9_one_driven: assert property (@(posedge clk) disable iff (rst)
        (seg != SEG_IDLE && !inhibit) |-> (pos ^ neg));

    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        inhibit |-> (!pos && !neg));

    a_r4_mid_flip: assert property (@(posedge clk) disable iff (rst)
        ((seg == SEG_DATA || seg == SEG_PAR) && !hc[0] && !inhibit)
        |=> (inhibit || (pos == $past(neg) && neg == $past(pos))));

    a_r3_sync_flip: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_SYNC && hc == HALF_W'(2) && !inhibit)
        |=> (inhibit || (pos == $past(neg) && neg == $past(pos))));

endmodule

// File: rtl/manch_frame_enc.sv
module manch_frame_enc
    import mfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             send,
    input  logic [LEN_W-1:0] word_len,
    input  logic             cmd_sync,
    input  logic             odd_par,
    input  logic             ser_in,
    input  logic             inhibit,
    output logic             line_pos,
    output logic             line_neg,
    output logic             shift_stb,
    output logic             busy
);

    logic              active;
    logic [HALF_W-1:0] hc;
    cfg_t              cfg;
    seg_e              seg;
    logic              load_bit;
    logic              cur_bit;
    logic              par_acc;
    logic              start;

    assign start = send && !active;

    mfe_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .send     (send),
        .len_in   (word_len),
        .sync_in  (cmd_sync),
        .odd_in   (odd_par),
        .active   (active),
        .hc       (hc),
        .cfg      (cfg),
        .seg      (seg),
        .strobe   (shift_stb),
        .load_bit (load_bit)
    );

    mfe_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load_bit (load_bit),
        .ser_in   (ser_in),
        .cur_bit  (cur_bit),
        .par_acc  (par_acc)
    );

    mfe_line u_line (
        .clk     (clk),
        .rst     (rst),
        .seg     (seg),
        .hc      (hc),
        .cmd     (cfg.cmd),
        .odd     (cfg.odd),
        .cur_bit (cur_bit),
        .par_acc (par_acc),
        .inhibit (inhibit),
        .pos     (line_pos),
        .neg     (line_neg)
    );

    assign busy = active;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!line_pos && !line_neg && !shift_stb));

endmodule

// File: tb/sim_manch_frame_enc.sv
`timescale 1ns/1ps
module sim_manch_frame_enc;

    typedef struct packed {
        logic [4:0]  len;
        logic        cmd;
        logic        odd;
        logic        inh;
        logic [27:0] data;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TAB [NV] = '{
        '{5'd16, 1'b1, 1'b1, 1'b0, 28'h000A5C3},
        '{5'd16, 1'b0, 1'b0, 1'b0, 28'h000FFFF},
        '{5'd2,  1'b1, 1'b0, 1'b0, 28'h0000002},
        '{5'd28, 1'b0, 1'b1, 1'b0, 28'hA5A5A5A},
        '{5'd0,  1'b1, 1'b0, 1'b0, 28'h0000003},
        '{5'd31, 1'b0, 1'b0, 1'b0, 28'hFFFFFFF},
        '{5'd1,  1'b0, 1'b1, 1'b0, 28'h0000001},
        '{5'd12, 1'b1, 1'b0, 1'b1, 28'h0000123}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1, send = 1'b0, cmd_sync = 1'b0, odd_par = 1'b0;
    logic       ser_in = 1'b0, inhibit = 1'b0;
    logic [4:0] word_len = 5'd0;
    logic       line_pos, line_neg, shift_stb, busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    manch_frame_enc u0 (
        .clk(clk), .rst(rst), .send(send), .word_len(word_len),
        .cmd_sync(cmd_sync), .odd_par(odd_par), .ser_in(ser_in),
        .inhibit(inhibit), .line_pos(line_pos), .line_neg(line_neg),
        .shift_stb(shift_stb), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff_len(input logic [4:0] l);
        if (l < 5'd2) return 2;
        if (l > 5'd28) return 28;
        return int'(l);
    endfunction

    function automatic logic exp_level(input vec_t v, input int n, input int h);
        logic p;
        if (h < 6) return (h < 3) ? v.cmd : !v.cmd;
        if (h < 6 + 2 * n) return v.data[(h - 6) / 2] ^ h[0];
        p = v.odd;
        for (int i = 0; i < n; i++) p ^= v.data[i];
        return p ^ h[0];
    endfunction

    task automatic run_frame(input vec_t v, input string tag);
        int n = eff_len(v.len);
        int frame = 2 * (n + 4);
        int nstb = 0, busy_cnt = 0;
        bit ok_sync = 1, ok_data = 1, ok_par = 1, ok_inh = 1, ok_excl = 1, ok_stb = 1;
        int a_sync = 0, e_sync = 0, a_data = 0, e_data = 0, a_par = 0, e_par = 0;
        @(negedge clk);
        word_len = v.len; cmd_sync = v.cmd; odd_par = v.odd; inhibit = v.inh;
        send = 1'b1; ser_in = 1'b0;
        for (int h = 0; h < frame; h++) begin
            logic lv, ep, en;
            int got, want;
            @(negedge clk);
            if (h == 0) begin
                send = 1'b0;
                word_len = ~v.len; cmd_sync = ~v.cmd; odd_par = ~v.odd;
            end
            if (h == 1) send = 1'b1;   // R10: ignored while busy
            if (h == 2) send = 1'b0;
            lv = exp_level(v, n, h);
            ep = !v.inh && lv;
            en = !v.inh && !lv;
            got  = {30'd0, line_pos, line_neg};
            want = {30'd0, ep, en};
            if (busy) busy_cnt++;
            if (line_pos && line_neg) ok_excl = 0;
            if (shift_stb !== ((h % 2 == 0) && h >= 4 && h <= 2 * n + 2)) ok_stb = 0;
            if (got != want) begin
                if (v.inh) ok_inh = 0;
                else if (h < 6) begin
                    if (ok_sync) begin a_sync = got; e_sync = want; end
                    ok_sync = 0;
                end else if (h < 6 + 2 * n) begin
                    if (ok_data) begin a_data = got; e_data = want; end
                    ok_data = 0;
                end else begin
                    if (ok_par) begin a_par = got; e_par = want; end
                    ok_par = 0;
                end
            end
            if (shift_stb) begin
                ser_in = (nstb < 28) ? v.data[nstb] : 1'b0;
                nstb++;
            end
        end
        @(negedge clk);
        if (busy) busy_cnt++;
        if (v.inh) begin
            check(ok_inh, {"R8 quiet line ", tag}, 0, 1);
        end else begin
            check(ok_sync, {"R3 sync ", tag}, a_sync, e_sync);
            check(ok_data, {"R4 data ", tag}, a_data, e_data);
            check(ok_par,  {"R6 parity ", tag}, a_par, e_par);
            check(ok_excl, {"R9 exclusive ", tag}, 0, 1);
        end
        check(ok_stb && nstb == n, {"R5 strobes ", tag}, nstb, n);
        check(busy_cnt == frame,
              (v.len < 5'd2 || v.len > 5'd28) ? {"R7 clamped length ", tag}
                                               : {"R2 R10 frame length ", tag},
              busy_cnt, frame);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !line_pos && !line_neg && !shift_stb, "R1 reset state",
              {28'd0, busy, line_pos, line_neg, shift_stb}, 0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++) run_frame(TAB[i], $sformatf("vec%0d", i));

        // R1: reset mid-frame
        @(negedge clk);
        word_len = 5'd10; cmd_sync = 1'b1; odd_par = 1'b0; inhibit = 1'b0; send = 1'b1;
        @(negedge clk); send = 1'b0;
        repeat (8) @(negedge clk);
        check(busy, "R1 frame running before reset", {31'd0, busy}, 1);
        rst = 1'b1;
        @(negedge clk);
        check(!busy && !line_pos && !line_neg && !shift_stb, "R1 mid-frame reset",
              {28'd0, busy, line_pos, line_neg, shift_stb}, 0);
        rst = 1'b0;
        run_frame(TAB[1], "after reset");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule